// File: doc/BRIEF.md
# Multi-Mode Programmable Frequency Divider

This block is the feedback divider of a frequency synthesizer loop. It counts pulses from one of two input strobes, a high-band input and a low-band input, and issues a one-clock output strobe each time a full division cycle has been counted. Both inputs are clock-enable strobes sampled in a single system clock domain.

A 16-bit control word and two mode bits are loaded together with a synchronous load strobe. The mode bits choose three things at once: which input is counted, which bit of the word is its least significant bit, and whether the counted ratio is twice the set value. Each mode has its own minimum set value. A value below that minimum is replaced by the minimum, and a one-clock flag reports the replacement. A loaded word is held as pending and only takes over at the next terminal count, so a running division cycle is never cut short. An inhibit input freezes the divider. On release, the divider restarts from the pending word.

Top module: `fbdiv_top`

## Requirements
- R1: After reset, `div_pulse` and `clamp_flag` are low, and the divider runs in the fine low-band mode with a ratio of 272.
- R2: High-band mode (`cfg_high_band`=1, `cfg_fine_step` ignored) counts only `hb_strobe`. The ratio is twice the 16-bit set value `cfg_word`.
- R3: Fine low-band mode (`cfg_high_band`=0, `cfg_fine_step`=1) counts only `lb_strobe`. The ratio equals the 16-bit set value.
- R4: Coarse low-band mode (`cfg_high_band`=0, `cfg_fine_step`=0) counts only `lb_strobe`. The ratio is `cfg_word[15:4]`, and `cfg_word[3:0]` has no effect.
- R5: A set value below the mode minimum (272 in the high-band and fine modes, 4 in coarse mode) is replaced by that minimum. `clamp_flag` is high for exactly the one cycle after the load edge. A value at the minimum raises no flag.
- R6: A loaded word and mode take effect only when the division cycle in progress ends. The cycle that contains the load completes with the previous ratio.
- R7: `div_pulse` is high for one cycle. It appears in the cycle after the clock edge that samples the final counted strobe of a division cycle.
- R8: While `inhibit` is high, strobes are not counted and `div_pulse` stays low.
- R9: After `inhibit` falls, the next division cycle counts the full ratio of the pending word, starting with the first strobe sampled after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_strobe | input | 1 | High-band input pulse, one clock enable per input edge |
| lb_strobe | input | 1 | Low-band input pulse, one clock enable per input edge |
| inhibit | input | 1 | Freezes counting and output while high |
| cfg_load | input | 1 | Captures word and mode bits at the clock edge |
| cfg_word | input | 16 | Division set value |
| cfg_high_band | input | 1 | Selects the high-band input with a doubled ratio |
| cfg_fine_step | input | 1 | In low-band: 1 selects full-word resolution, 0 selects the coarse field |
| div_pulse | output | 1 | One-clock strobe per completed division cycle |
| clamp_flag | output | 1 | One-clock flag that a loaded value was raised to the minimum |

## Verification
`div_pulse` is registered, so it is due in the cycle after the edge that samples the final counted strobe. `clamp_flag` is due in the cycle after the load edge. A new word shows up only in the spacing of the second pulse after the load, because the pulse that ends the current cycle still follows the old ratio. The bench drives inputs on the falling edge and compares both outputs against a cycle model on the next falling edge, so every check lands one full register stage after its stimulus. For each mode, it counts the strobes on the expected input between consecutive `div_pulse` events and compares that count with a ratio computed from the mode rules, including the period that spans a load and the first period after an inhibit release.

// File: rtl/fbdiv_pkg.sv
// Shared types for the feedback divider.
// Assumes the two mode bits are decoded in one place so every unit agrees.
package fbdiv_pkg;

    typedef enum logic [1:0] {
        MODE_COARSE = 2'b00,
        MODE_FINE   = 2'b01,
        MODE_HIGH   = 2'b10
    } fb_mode_e;

    // Mode decode: the high-band bit dominates the fine-step bit.
    function automatic fb_mode_e decode_mode(input logic high_band, input logic fine_step);
        if (high_band) begin
            return MODE_HIGH;
        end else if (fine_step) begin
            return MODE_FINE;
        end
        return MODE_COARSE;
    endfunction

endpackage

// File: rtl/fbdiv_cfg.sv
// Pending configuration register for the feedback divider.
// Extracts the set value for the selected mode, raises it to the mode
// minimum when needed, applies doubling and holds the resulting ratio until
// the counter takes it. Assumes MIN values fit in the set field.
module fbdiv_cfg
    import fbdiv_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int COARSE_SHIFT = 4,
    parameter int MIN_FULL     = 272,
    parameter int MIN_COARSE   = 4,
    parameter int RESET_SET    = 272,
    localparam int CNT_W       = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              high_band,
    input  logic              fine_step,
    output logic [CNT_W-1:0]  pend_ratio,
    output fb_mode_e          pend_mode,
    output logic              clamp_flag
);

    fb_mode_e           mode_in;
    logic [CNT_W-1:0]   set_full;
    logic [CNT_W-1:0]   set_coarse;
    logic [CNT_W-1:0]   set_sel;
    logic [CNT_W-1:0]   set_min;
    logic               doubled;
    logic               below;
    logic [CNT_W-1:0]   set_eff;
    logic [CNT_W-1:0]   ratio_in;

    // Decode the incoming mode bits.
    assign mode_in    = decode_mode(high_band, fine_step);
    assign set_full   = CNT_W'(word);
    assign set_coarse = CNT_W'(word >> COARSE_SHIFT);

    // Pick set field, minimum and doubling for the incoming mode.
    always_comb begin
        case (mode_in)
            MODE_HIGH: begin
                set_sel = set_full;
                set_min = CNT_W'(MIN_FULL);
                doubled = 1'b1;
            end
            MODE_FINE: begin
                set_sel = set_full;
                set_min = CNT_W'(MIN_FULL);
                doubled = 1'b0;
            end
            default: begin
                set_sel = set_coarse;
                set_min = CNT_W'(MIN_COARSE);
                doubled = 1'b0;
            end
        endcase
    end

    // Clamp to the floor and apply doubling.
    assign below    = (set_sel < set_min);
    assign set_eff  = below ? set_min : set_sel;
    assign ratio_in = doubled ? (set_eff << 1) : set_eff;

    // Hold the pending ratio and mode, and update them on each load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ratio <= CNT_W'(RESET_SET);
            pend_mode  <= MODE_FINE;
        end else if (load) begin
            pend_ratio <= ratio_in;
            pend_mode  <= mode_in;
        end
    end

    // One-cycle report of a raised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_flag <= 1'b0;
        end else begin
            clamp_flag <= load && below;
        end
    end

endmodule

// File: rtl/fbdiv_srcsel.sv
// Input source selector.
// Passes the strobe of the input that the active mode counts. Assumes both
// strobes are already synchronous single-clock enables.
module fbdiv_srcsel
    import fbdiv_pkg::*;
(
    input  fb_mode_e act_mode,
    input  logic     hb_strobe,
    input  logic     lb_strobe,
    output logic     sel_strobe
);

    // The high-band mode counts the high input; the other modes count the low input.
    always_comb begin
        sel_strobe = (act_mode == MODE_HIGH) ? hb_strobe : lb_strobe;
    end

endmodule

// File: rtl/fbdiv_counter.sv
// Down counter with terminal-count reload.
// Counts selected strobes from ratio-1 down to zero. At zero it issues a
// registered strobe and reloads from the pending ratio and mode. Inhibit holds
// the counter preloaded from the pending word. Assumes RESET_RATIO >= 1.
module fbdiv_counter
    import fbdiv_pkg::*;
#(
    parameter int CNT_W       = 17,
    parameter int RESET_RATIO = 272
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit,
    input  logic             strobe,
    input  logic [CNT_W-1:0] pend_ratio,
    input  fb_mode_e         pend_mode,
    output fb_mode_e         act_mode,
    output logic             tc_pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;
    logic             wrap;
    logic             reload;

    assign at_zero = (cnt_q == '0);
    assign wrap    = !inhibit && strobe && at_zero;
    assign reload  = inhibit || wrap;

    // Take over the pending mode at terminal count or while inhibited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= MODE_FINE;
        end else if (reload) begin
            act_mode <= pend_mode;
        end
    end

    // Count down on each selected strobe, and reload on wrap or inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_RATIO - 1);
        end else if (reload) begin
            cnt_q <= pend_ratio - 1'b1;
        end else if (strobe) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Register the end-of-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= wrap;
        end
    end

endmodule

// File: rtl/fbdiv_top.sv
// Multi-mode feedback divider top.
// Joins the pending configuration, the source selector and the reload
// counter. Assumes single clock domain and synchronous active-low reset.
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int COARSE_SHIFT = 4,
    parameter int MIN_FULL     = 272,
    parameter int MIN_COARSE   = 4,
    parameter int RESET_SET    = 272
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_strobe,
    input  logic              lb_strobe,
    input  logic              inhibit,
    input  logic              cfg_load,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_high_band,
    input  logic              cfg_fine_step,
    output logic              div_pulse,
    output logic              clamp_flag
);

    localparam int CNT_W = WORD_W + 1;

    logic [CNT_W-1:0] pend_ratio;
    fb_mode_e         pend_mode;
    fb_mode_e         act_mode;
    logic             sel_strobe;

    fbdiv_cfg #(
        .WORD_W       (WORD_W),
        .COARSE_SHIFT (COARSE_SHIFT),
        .MIN_FULL     (MIN_FULL),
        .MIN_COARSE   (MIN_COARSE),
        .RESET_SET    (RESET_SET)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .word       (cfg_word),
        .high_band  (cfg_high_band),
        .fine_step  (cfg_fine_step),
        .pend_ratio (pend_ratio),
        .pend_mode  (pend_mode),
        .clamp_flag (clamp_flag)
    );

    fbdiv_srcsel u_sel (
        .act_mode   (act_mode),
        .hb_strobe  (hb_strobe),
        .lb_strobe  (lb_strobe),
        .sel_strobe (sel_strobe)
    );

    fbdiv_counter #(
        .CNT_W       (CNT_W),
        .RESET_RATIO (RESET_SET)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inhibit    (inhibit),
        .strobe     (sel_strobe),
        .pend_ratio (pend_ratio),
        .pend_mode  (pend_mode),
        .act_mode   (act_mode),
        .tc_pulse   (div_pulse)
    );

endmodule

// File: rtl/fbdiv_checker.sv
// Property checker for the feedback divider, attached to the top by bind.
// Assumes the minimum ratio is at least 2, so output strobes never touch.
module fbdiv_checker #(
    parameter int CNT_W      = 17,
    parameter int MIN_COARSE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inhibit,
    input logic             cfg_load,
    input logic             sel_strobe,
    input logic [CNT_W-1:0] pend_ratio,
    input logic             div_pulse,
    input logic             clamp_flag
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R7

    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> ($past(sel_strobe) && !$past(inhibit))); // R7

    AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> !div_pulse); // R8

    AST_FLAG_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_flag |-> $past(cfg_load)); // R5

    AST_FLAG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_flag && !cfg_load) |=> !clamp_flag); // R5

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ratio >= CNT_W'(MIN_COARSE)); // R5

    AST_PENDING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(pend_ratio)); // R6

endmodule

bind fbdiv_top fbdiv_checker #(
    .CNT_W      (CNT_W),
    .MIN_COARSE (MIN_COARSE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inhibit    (inhibit),
    .cfg_load   (cfg_load),
    .sel_strobe (sel_strobe),
    .pend_ratio (pend_ratio),
    .div_pulse  (div_pulse),
    .clamp_flag (clamp_flag)
);

// File: tb/fbdiv_top_tb.sv
module fbdiv_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        d_hb = 1'b0, d_lb = 1'b0, d_inh = 1'b0, d_ld = 1'b0;
    logic        d_hband = 1'b0, d_fine = 1'b0;
    logic [15:0] d_word = '0;
    logic        div_pulse, clamp_flag;

    int checks = 0, failures = 0;
    int p_hb = 0, p_lb = 0;
    // reference state
    int mp_ratio, ma_unused;
    bit mp_hi, ma_hi, m_out, m_err;
    int mcnt;
    // measurement against the design's pulses
    int since = 0, ngaps = 0, npulse = 0;
    int gaps[8];

    fbdiv_top dut_i (
        .clk(clk), .rst_n(rst_n), .hb_strobe(d_hb), .lb_strobe(d_lb),
        .inhibit(d_inh), .cfg_load(d_ld), .cfg_word(d_word),
        .cfg_high_band(d_hband), .cfg_fine_step(d_fine),
        .div_pulse(div_pulse), .clamp_flag(clamp_flag)
    );

    always #10 clk = ~clk;

    function automatic int set_of(int w, bit hb, bit fn);
        if (hb || fn) return w & 16'hFFFF;
        return (w & 16'hFFFF) >> 4;
    endfunction

    function automatic int min_of(bit hb, bit fn);
        return (hb || fn) ? 272 : 4;
    endfunction

    function automatic bit exp_err(int w, bit hb, bit fn);
        return set_of(w, hb, fn) < min_of(hb, fn);
    endfunction

    function automatic int exp_ratio(int w, bit hb, bit fn);
        int s;
        s = set_of(w, hb, fn);
        if (s < min_of(hb, fn)) s = min_of(hb, fn);
        return hb ? 2 * s : s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mp_ratio = 272; mp_hi = 0; ma_hi = 0; mcnt = 271; m_out = 0; m_err = 0;
        since = 0;
    endtask

    // Advance the cycle model by one edge using the inputs seen at that edge.
    task automatic model_step();
        int  n_ratio;
        bit  n_hi, sel;
        n_ratio = d_ld ? exp_ratio(d_word, d_hband, d_fine) : mp_ratio;
        n_hi    = d_ld ? d_hband : mp_hi;
        m_err   = d_ld && exp_err(d_word, d_hband, d_fine);
        sel     = ma_hi ? d_hb : d_lb;
        m_out   = 0;
        if (d_inh) begin
            ma_hi = mp_hi; mcnt = mp_ratio - 1;
        end else if (sel) begin
            if (mcnt == 0) begin
                m_out = 1; ma_hi = mp_hi; mcnt = mp_ratio - 1;
            end else begin
                mcnt--;
            end
        end
        mp_ratio = n_ratio; mp_hi = n_hi;
    endtask

    task automatic tick();
        d_hb = ($urandom_range(99) < p_hb);
        d_lb = ($urandom_range(99) < p_lb);
        @(posedge clk);
        if (d_inh) since = 0;
        else if (ma_hi ? d_hb : d_lb) since++;
        model_step();
        @(negedge clk);
        check(div_pulse === m_out, "R7 div_pulse", int'(div_pulse), int'(m_out));
        check(clamp_flag === m_err, "R5 clamp_flag", int'(clamp_flag), int'(m_err));
        if (div_pulse === 1'b1) begin
            npulse++;
            if (ngaps < 8) gaps[ngaps] = since;
            ngaps++;
            since = 0;
        end
        d_ld = 1'b0;
    endtask

    task automatic load(input int w, input bit hb, input bit fn);
        d_word = 16'(w); d_hband = hb; d_fine = fn; d_ld = 1'b1;
        tick();
        check(clamp_flag === exp_err(w, hb, fn), "R5 flag after load",
              int'(clamp_flag), int'(exp_err(w, hb, fn)));
    endtask

    task automatic wait_gaps(input int k, input int limit);
        int n = 0;
        ngaps = 0;
        while (ngaps < k && n < limit) begin
            tick();
            n++;
        end
        check(ngaps >= k, "R7 pulses seen", ngaps, k);
    endtask

    initial begin
        #3600000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check(div_pulse === 1'b0, "R1 div_pulse after reset", int'(div_pulse), 0);
        check(clamp_flag === 1'b0, "R1 clamp_flag after reset", int'(clamp_flag), 0);

        // R1 default ratio in fine low-band mode, high input noisy
        p_lb = 100; p_hb = 50;
        wait_gaps(2, 2000);
        check(gaps[0] == 272, "R1 reset ratio", gaps[0], 272);
        check(gaps[1] == 272, "R3 reset ratio repeat", gaps[1], 272);

        // R2 high band, load mid-cycle (R6)
        p_hb = 70; p_lb = 60;
        repeat (50) tick();
        load(300, 1'b1, 1'b0);
        wait_gaps(3, 6000);
        check(gaps[0] == 272, "R6 old ratio completes", gaps[0], 272);
        check(gaps[1] == 600, "R2 doubled ratio", gaps[1], 600);
        check(gaps[2] == 600, "R2 doubled ratio repeat", gaps[2], 600);

        // R3 fine low band with the high input saturated; SNS ignored case in R2 first
        p_hb = 100; p_lb = 80;
        load(400, 1'b1, 1'b1);
        wait_gaps(2, 4000);
        check(gaps[1] == 800, "R2 fine bit ignored in high band", gaps[1], 800);
        load(1000, 1'b0, 1'b1);
        wait_gaps(2, 6000);
        check(gaps[0] == 800, "R6 old ratio completes", gaps[0], 800);
        check(gaps[1] == 1000, "R3 fine ratio", gaps[1], 1000);

        // R4 coarse: low nibble ignored
        load(16'h0A5F, 1'b0, 1'b0);
        wait_gaps(2, 4000);
        check(gaps[1] == 165, "R4 coarse ratio", gaps[1], 165);
        load(16'h0A50, 1'b0, 1'b0);
        wait_gaps(2, 2000);
        check(gaps[1] == 165, "R4 low bits no effect", gaps[1], 165);

        // R5 clamp in fine and coarse modes, and boundary without flag
        load(100, 1'b0, 1'b1);
        check(clamp_flag === 1'b1, "R5 fine below floor", int'(clamp_flag), 1);
        wait_gaps(2, 2000);
        check(gaps[1] == 272, "R5 fine floor ratio", gaps[1], 272);
        load(16'h002F, 1'b0, 1'b0);
        check(clamp_flag === 1'b1, "R5 coarse below floor", int'(clamp_flag), 1);
        tick();
        check(clamp_flag === 1'b0, "R5 flag lasts one cycle", int'(clamp_flag), 0);
        wait_gaps(3, 2000);
        check(gaps[1] == 4, "R5 coarse floor ratio", gaps[1], 4);
        load(16'h0040, 1'b0, 1'b0);
        check(clamp_flag === 1'b0, "R5 at floor no flag", int'(clamp_flag), 0);
        load(272, 1'b1, 1'b0);
        check(clamp_flag === 1'b0, "R5 high at floor no flag", int'(clamp_flag), 0);

        // R8 inhibit, R9 release reload
        load(500, 1'b0, 1'b1);
        p_hb = 100; p_lb = 100;
        repeat (37) tick();
        d_inh = 1'b1;
        npulse = 0;
        repeat (1200) tick();
        check(npulse == 0, "R8 no pulses while inhibited", npulse, 0);
        d_inh = 1'b0;
        p_lb = 60;
        wait_gaps(2, 3000);
        check(gaps[0] == 500, "R9 full ratio after release", gaps[0], 500);
        check(gaps[1] == 500, "R9 ratio steady", gaps[1], 500);

        // Random phase: mixed loads, modes, inhibit and strobe densities
        for (int i = 0; i < 20000; i++) begin
            p_hb = $urandom_range(100);
            p_lb = $urandom_range(100);
            if ($urandom_range(99) < 2) d_inh = ~d_inh;
            if ($urandom_range(199) == 0) begin
                bit hb, fn;
                int w;
                hb = $urandom_range(1); fn = $urandom_range(1);
                w  = (hb || fn) ? $urandom_range(700) : $urandom_range(16 * 200);
                d_word = 16'(w); d_hband = hb; d_fine = fn; d_ld = 1'b1;
            end
            tick();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule